// File: doc/BRIEF.md
# Four-slot instruction issue allocator

This block sits between an instruction decoder and four issue slots. Every cycle it looks at a bundle of up to four decoded instructions, given in program order. Each instruction carries a class code, and the block places each one on a slot whose execution units can run that class. Slots 0 and 1 are served by one dual-issue queue and slots 2 and 3 by another. Each slot has its own set of units, so the mapping from class to slot is fixed and uneven:

- Loads and prefetches can use only slot 0.
- Stores can use only slot 1.
- Integer operations may use slot 2 or slot 3.
- Floating-point and SIMD work can use only slot 3.
- A single-issue class occupies the whole machine for its cycle.

Allocation is strictly in order. Lane 0 is placed first, and the first lane that cannot be placed stops every lane after it. The front end reads the accepted count and advances its window by that many instructions. The lanes that were not accepted are presented again in the following cycle. All outputs are registered. A bundle sampled at one rising edge produces its grants, its slot numbers and its count right after that edge.

Top module: `issue_slot_alloc`

## Requirements
- R1: A load or prefetch (class code 0) is granted only on slot 0.
- R2: A store (class code 1) is granted only on slot 1.
- R3: An integer operation (class code 2) takes slot 2 if no earlier lane holds it, and slot 3 otherwise. Two granted lanes never report the same slot.
- R4: A floating-point or SIMD operation (class code 3) is granted only on slot 3.
- R5: A single-issue instruction (class code 4; codes 5 to 7 are handled the same way) is granted only in lane 0 and reports slot 0. No other lane is granted in that cycle. In any later lane it is not granted, and it stops the lanes after it.
- R6: The first valid lane that cannot be placed blocks every later lane, even one whose slot is free. The grant vector is always a run of ones starting at lane 0.
- R7: A lane whose valid bit is low is not granted, and it stops allocation for the lanes after it. An empty bundle gives no grants.
- R8: The accepted count equals the number of granted lanes, from 0 to 4.
- R9: Grants, slot numbers and the count reflect the bundle sampled at the previous rising edge, and they hold steady between edges.
- R10: Synchronous reset clears all grants and slot numbers and sets the count to zero. A lane that is not granted reports slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bundle_valid | input | LANES (4) | Per-lane valid bits, with lane 0 oldest |
| bundle_cls | input | LANES*3 (12) | Class code per lane; lane i occupies bits [3i+2:3i] |
| lane_grant | output | LANES (4) | Per-lane grant, registered |
| lane_slot | output | LANES*2 (8) | Chosen slot per lane; lane i occupies bits [2i+1:2i]; 0 when not granted |
| accept_count | output | 3 | Number of lanes granted, registered |

## Verification
The bundles mix the classes in ways that separate the rules from one another. In one bundle all four slots fill at once. In others, two integer operations take slots 2 and 3 in order and leave a floating-point operation stranded. When a floating-point operation comes before an integer one, the integer operation must still fall back to slot 2. Other patterns cover:

- Two loads, where the second blocks a store that would otherwise fit.
- Single-issue codes placed first and placed later in the bundle.
- Valid masks with a gap in them, and a fully empty bundle.

Directed steps then check the reset values, clearing during a run, and that the outputs change only at the clock edge.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

  localparam int CLS_W     = 3;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  // slot roles; the allocator's fallback order depends on INT_A < INT_B
  localparam int SLOT_LD    = 0;
  localparam int SLOT_ST    = 1;
  localparam int SLOT_INT_A = 2;
  localparam int SLOT_INT_B = 3;
  localparam int SLOT_FPG   = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_LOAD  = 3'd0,
    CLS_STORE = 3'd1,
    CLS_INT   = 3'd2,
    CLS_FPG   = 3'd3,
    CLS_SOLO  = 3'd4
  } cls_e;

endpackage

// File: rtl/slot_class_map.sv
module slot_class_map
  import slot_alloc_pkg::*;
(
  input  logic [CLS_W-1:0]     cls,
  output logic [NUM_SLOTS-1:0] perm,
  output logic                 solo
);

  always_comb begin
    perm = '0;
    solo = 1'b0;
    case (cls)
      CLS_LOAD:  perm[SLOT_LD] = 1'b1;
      CLS_STORE: perm[SLOT_ST] = 1'b1;
      CLS_INT: begin
        perm[SLOT_INT_A] = 1'b1;
        perm[SLOT_INT_B] = 1'b1;
      end
      CLS_FPG:   perm[SLOT_FPG] = 1'b1;
      default: begin
        // single-issue and unassigned codes claim every slot
        perm = '1;
        solo = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/lane_pick.sv
module lane_pick
  import slot_alloc_pkg::*;
#(
  parameter bit FIRST = 1'b0
) (
  input  logic                 enable,
  input  logic [NUM_SLOTS-1:0] free,
  input  logic [NUM_SLOTS-1:0] perm,
  input  logic                 solo,
  output logic                 grant,
  output logic [SLOT_W-1:0]    slot,
  output logic [NUM_SLOTS-1:0] take
);

  logic [NUM_SLOTS-1:0] avail;
  logic                 found;
  logic [SLOT_W-1:0]    low;

  assign avail = free & perm;

  // lowest free permitted slot wins
  always_comb begin
    found = 1'b0;
    low   = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (avail[s]) begin
        found = 1'b1;
        low   = SLOT_W'(s);
      end
    end
  end

  always_comb begin
    grant = 1'b0;
    slot  = '0;
    take  = '0;
    if (enable) begin
      if (solo) begin
        if (FIRST && (free == '1)) begin
          grant = 1'b1;
          take  = '1;
        end
      end else if (found) begin
        grant = 1'b1;
        slot  = low;
        take  = NUM_SLOTS'(1) << low;
      end
    end
  end

endmodule

// File: rtl/alloc_chain.sv
module alloc_chain
  import slot_alloc_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]        valid,
  input  logic [LANES*CLS_W-1:0]  cls,
  output logic [LANES-1:0]        grant,
  output logic [LANES*SLOT_W-1:0] slot,
  output logic [CNT_W-1:0]        count
);

  logic [NUM_SLOTS-1:0] free_v [LANES+1];
  logic [LANES:0]       go;

  assign free_v[0] = '1;
  assign go[0]     = 1'b1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [NUM_SLOTS-1:0] perm;
    logic                 solo;
    logic [NUM_SLOTS-1:0] take;
    logic                 g;

    slot_class_map u_map (
      .cls  (cls[i*CLS_W +: CLS_W]),
      .perm (perm),
      .solo (solo)
    );

    lane_pick #(.FIRST(i == 0)) u_pick (
      .enable (go[i] & valid[i]),
      .free   (free_v[i]),
      .perm   (perm),
      .solo   (solo),
      .grant  (g),
      .slot   (slot[i*SLOT_W +: SLOT_W]),
      .take   (take)
    );

    assign grant[i]    = g;
    assign go[i+1]     = g;
    assign free_v[i+1] = free_v[i] & ~take;
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < LANES; i++) begin
      count = count + CNT_W'(grant[i]);
    end
  end

endmodule

// File: rtl/issue_slot_alloc.sv
module issue_slot_alloc
  import slot_alloc_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LANES-1:0]            bundle_valid,
  input  logic [LANES*CLS_W-1:0]      bundle_cls,
  output logic [LANES-1:0]            lane_grant,
  output logic [LANES*SLOT_W-1:0]     lane_slot,
  output logic [CNT_W-1:0]            accept_count
);

  logic [LANES-1:0]        grant_d;
  logic [LANES*SLOT_W-1:0] slot_d;
  logic [CNT_W-1:0]        count_d;

  alloc_chain #(.LANES(LANES)) u_chain (
    .valid (bundle_valid),
    .cls   (bundle_cls),
    .grant (grant_d),
    .slot  (slot_d),
    .count (count_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_grant   <= '0;
      lane_slot    <= '0;
      accept_count <= '0;
    end else begin
      lane_grant   <= grant_d;
      lane_slot    <= slot_d;
      accept_count <= count_d;
    end
  end

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    accept_count == CNT_W'($countones(lane_grant))); // R8

  AST_EMPTY_BUNDLE: assert property (@(posedge clk) disable iff (rst)
    !bundle_valid[0] |=> accept_count == '0); // R7

  AST_LOAD_HEAD: assert property (@(posedge clk) disable iff (rst)
    (bundle_valid[0] && bundle_cls[CLS_W-1:0] == CLS_LOAD)
      |=> (lane_grant[0] && lane_slot[SLOT_W-1:0] == SLOT_W'(SLOT_LD))); // R1

  AST_SOLO_ALONE: assert property (@(posedge clk) disable iff (rst)
    (bundle_valid[0] && bundle_cls[CLS_W-1:0] >= CLS_SOLO)
      |=> (lane_grant == LANES'(1) && lane_slot[SLOT_W-1:0] == '0)); // R5

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
      !lane_grant[i] |-> lane_slot[i*SLOT_W +: SLOT_W] == '0); // R10
    if (i > 0) begin : g_prefix
      AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
        lane_grant[i] |-> lane_grant[i-1]); // R6
    end
    for (genvar j = i + 1; j < LANES; j++) begin : g_pair
      AST_SLOT_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (lane_grant[i] && lane_grant[j])
          |-> lane_slot[i*SLOT_W +: SLOT_W] != lane_slot[j*SLOT_W +: SLOT_W]); // R3
    end
  end

endmodule

// File: tb/issue_slot_alloc_tb.sv
module issue_slot_alloc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int NV         = 12;

  // {valid[4], cls3,cls2,cls1,cls0, grant[4], slot3,slot2,slot1,slot0, count[3]}
  // class codes: 0 load, 1 store, 2 int, 3 fp/simd, 4 single-issue, 6 reserved
  localparam logic [30:0] VEC [NV] = '{
    // R1 R2 R3 R4: L,S,I,F fill all slots
    {4'hF, 3'd3,3'd2,3'd1,3'd0, 4'hF, 2'd3,2'd2,2'd1,2'd0, 3'd4},
    // R3 R6: I,I,F,L -> 2,3 then F blocked
    {4'hF, 3'd0,3'd3,3'd2,3'd2, 4'h3, 2'd0,2'd0,2'd3,2'd2, 3'd2},
    // R3: I,F,I,L -> 2,3, third I blocked
    {4'hF, 3'd0,3'd2,3'd3,3'd2, 4'h3, 2'd0,2'd0,2'd3,2'd2, 3'd2},
    // R6: L,L,S,I -> second load blocks fitting store
    {4'hF, 3'd2,3'd1,3'd0,3'd0, 4'h1, 2'd0,2'd0,2'd0,2'd0, 3'd1},
    // R5: solo first
    {4'hF, 3'd2,3'd1,3'd0,3'd4, 4'h1, 2'd0,2'd0,2'd0,2'd0, 3'd1},
    // R5: solo in lane 1 waits
    {4'hF, 3'd2,3'd1,3'd4,3'd0, 4'h1, 2'd0,2'd0,2'd0,2'd0, 3'd1},
    // R3 R4: F,I -> F slot 3, I slot 2
    {4'h3, 3'd0,3'd1,3'd2,3'd3, 4'h3, 2'd0,2'd0,2'd2,2'd3, 3'd2},
    // R7: gap at lane 1
    {4'hD, 3'd2,3'd1,3'd1,3'd0, 4'h1, 2'd0,2'd0,2'd0,2'd0, 3'd1},
    // R7: empty bundle
    {4'h0, 3'd0,3'd1,3'd2,3'd3, 4'h0, 2'd0,2'd0,2'd0,2'd0, 3'd0},
    // R5: reserved code acts as solo
    {4'h3, 3'd0,3'd0,3'd0,3'd6, 4'h1, 2'd0,2'd0,2'd0,2'd0, 3'd1},
    // R2 R8: S,F,I,I -> 1,3,2, last blocked
    {4'hF, 3'd2,3'd2,3'd3,3'd1, 4'h7, 2'd0,2'd2,2'd3,2'd1, 3'd3},
    // R4: F,F -> second F blocked
    {4'h3, 3'd0,3'd0,3'd3,3'd3, 4'h1, 2'd0,2'd0,2'd0,2'd3, 3'd1}
  };
  localparam int VREQ [NV] = '{1, 3, 3, 6, 5, 5, 4, 7, 7, 5, 2, 4};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bundle_valid = '0;
  logic [11:0] bundle_cls = '0;
  logic [3:0]  lane_grant;
  logic [7:0]  lane_slot;
  logic [2:0]  accept_count;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_slot_alloc #(.LANES(LANES)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .bundle_valid (bundle_valid),
    .bundle_cls   (bundle_cls),
    .lane_grant   (lane_grant),
    .lane_slot    (lane_slot),
    .accept_count (accept_count)
  );

  task automatic check(input int req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] v, input logic [11:0] c);
    @(negedge clk);
    bundle_valid = v;
    bundle_cls   = c;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check(10, "reset grant", int'(lane_grant), 0);
    check(10, "reset slot", int'(lane_slot), 0);
    check(10, "reset count", int'(accept_count), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][30:27], VEC[k][26:15]);
      check(VREQ[k], $sformatf("vec %0d grant", k), int'(lane_grant), int'(VEC[k][14:11]));
      check(VREQ[k], $sformatf("vec %0d slot", k), int'(lane_slot), int'(VEC[k][10:3]));
      check(8, $sformatf("vec %0d count", k), int'(accept_count), int'(VEC[k][2:0]));
    end

    // R9: outputs hold until the edge
    apply(4'hF, {3'd3,3'd2,3'd1,3'd0});
    @(negedge clk);
    bundle_valid = 4'h1;
    bundle_cls   = {3'd0,3'd0,3'd0,3'd4};
    #1;
    check(9, "hold count before edge", int'(accept_count), 4);
    check(9, "hold grant before edge", int'(lane_grant), 4'hF);
    @(posedge clk);
    #1;
    check(9, "count after edge", int'(accept_count), 1);

    // R10: reset during operation clears outputs
    apply(4'hF, {3'd3,3'd2,3'd1,3'd0});
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(10, "mid reset grant", int'(lane_grant), 0);
    check(10, "mid reset count", int'(accept_count), 0);
    @(negedge clk);
    rst = 1'b0;
    bundle_valid = '0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule